// File: doc/BRIEF.md
# Select-Line Command Packet Receiver

This block takes a host's 128-bit command packet that arrives as a sequence of levels on two select lines. When both lines are low, the receiver restarts. When both are high, the line is idle and the receiver advances to the next bit. Between two idle states, the host pulls exactly one line low to send a bit. If line A is low, the bit is a zero. If line B is low, the bit is a one. After the 128 bits come in, the host marks the end of the packet with a zero-coded stop level. The receiver then pulses a valid strobe and holds the packet on its output until the next restart.

Once a packet has been accepted, the same lines carry a second handshake that selects the next player in a multiplayer setup. The host sends both single-line-low levels, in either order, and then returns to idle. This advances a controller index, which wraps under a player-count mask. The receiver does not decode the packet's contents.

The two line levels are synchronous inputs, sampled on every clock edge. Only a change of level is acted on. The single exception is the both-low restart level.

Top module: `cmd_pulse_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `pkt_valid` is 0, `ctrl_idx` is 0 and `pkt_data` is all zero.
- R2: The level value is {`sel_lines[1]`,`sel_lines[0]`}. The value 00 clears all of `pkt_data` by the next clock edge and restarts reception, so that the next 11 level starts bit 0. The clear happens even in the middle of a packet.
- R3: A level equal to the previously processed level (other than 00) has no effect on `pkt_data`, `pkt_valid` or `ctrl_idx`, however long it is held.
- R4: During reception, the level 01 writes a one and the level 10 leaves a zero at the current bit, and each new 11 level advances to the next bit. Packet bit k appears at `pkt_data[k]`, which is byte k/8, bit k%8, least significant bit first.
- R5: After bit 127 and the 11 that follows it, a 10 level (the stop bit) raises `pkt_valid` for exactly one cycle. The pulse appears on the cycle after the clock edge that samples the stop level.
- R6: At the stop position, 01 and 11 levels neither emit a packet nor change `pkt_data`. A later 10 level still emits the packet.
- R7: After a packet, once both a 01 level and a 10 level have been seen (in either order), the next 11 level sets `ctrl_idx` to (`ctrl_idx`+1) AND `player_mask`. A 11 level that follows only one of the two levels does not advance the index. The handshake can be repeated.
- R8: `player_mask` may be 0, 1 or 3. With 0 the index stays 0. With 1 it alternates between 0 and 1. With 3 it steps 0,1,2,3,0.
- R9: After emission, `pkt_data` holds the packet through any handshake levels until the next 00 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_lines | input | 2 | Select line levels; bit 0 is line A, bit 1 is line B |
| player_mask | input | 2 | Player-count mask for the controller index (0, 1 or 3) |
| pkt_data | output | 128 | Received packet, bit k is packet bit k |
| pkt_valid | output | 1 | One-cycle strobe when a packet completes |
| ctrl_idx | output | 2 | Current controller index |

## Verification
The assertions assume that `player_mask` is one of 0, 1 or 3 and that `sel_lines` is a synchronous level that can change on any clock edge. The "held level" assertion compares the current level against the receiver's own last-processed level, so it makes no assumption about how long the host holds each level. The stimulus drives levels only at the falling clock edge and holds each one for a random one to three cycles. It changes `player_mask` only between handshakes and only to the three allowed values. It keeps `sel_lines` at the idle level 11 while reset is asserted.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef logic [1:0] lines_t;
  localparam lines_t LV_RESTART = 2'b00;
  localparam lines_t LV_ONE     = 2'b01;
  localparam lines_t LV_ZERO    = 2'b10;
  localparam lines_t LV_IDLE    = 2'b11;
endpackage

// File: rtl/cpr_line_track.sv
module cpr_line_track
  import cpr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  lines_t lines_i,
  output logic   evt_o,
  output lines_t prev_o
);
  lines_t prev_q, prev_d;
  logic   prev_en;

  // A change of level, or the restart level at any time, is an event.
  always_comb begin
    evt_o   = (lines_i != prev_q) || (lines_i == LV_RESTART);
    prev_en = evt_o;
    prev_d  = lines_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= LV_IDLE;
    else if (prev_en) prev_q <= prev_d;
  end

  assign prev_o = prev_q;
endmodule

// File: rtl/cpr_seq.sv
module cpr_seq
  import cpr_pkg::*;
#(
  parameter int PKT_BITS = 128,
  parameter int CTRL_W   = 2,
  localparam int IDX_W   = $clog2(PKT_BITS + 8) + 1,
  localparam int POS_W   = $clog2(PKT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  lines_t            lvl_i,
  input  logic [CTRL_W-1:0] mask_i,
  output logic              clr_o,
  output logic              set_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              valid_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic signed [IDX_W-1:0] IDX_NONE = '1;
  localparam logic signed [IDX_W-1:0] IDX_STOP = IDX_W'(PKT_BITS);
  localparam logic signed [IDX_W-1:0] IDX_DONE = IDX_W'(PKT_BITS + 1);
  localparam logic signed [IDX_W-1:0] IDX_FULL = IDX_W'(PKT_BITS + 7);
  localparam logic signed [IDX_W-1:0] FLG_ONE  = IDX_W'(2);
  localparam logic signed [IDX_W-1:0] FLG_ZERO = IDX_W'(4);

  logic signed [IDX_W-1:0] idx_q, idx_w;
  logic [CTRL_W-1:0]       ctrl_q, ctrl_d;
  logic                    valid_q, emit;

  always_comb begin
    idx_w  = idx_q;
    ctrl_d = ctrl_q;
    clr_o  = 1'b0;
    set_o  = 1'b0;
    emit   = 1'b0;
    if (evt_i) begin
      if (lvl_i == LV_RESTART) begin
        idx_w = IDX_NONE;
        clr_o = 1'b1;
      end
      // Handshake phase: collect both single-low levels, then idle.
      if (idx_w > IDX_STOP) begin
        case (lvl_i)
          LV_ONE:  idx_w = idx_w | FLG_ONE;
          LV_ZERO: idx_w = idx_w | FLG_ZERO;
          LV_IDLE: if (idx_w == IDX_FULL) begin
                     idx_w  = idx_w & ~(FLG_ONE | FLG_ZERO);
                     ctrl_d = (ctrl_q + CTRL_W'(1)) & mask_i;
                   end
          default: ;
        endcase
      end
      // Stop bit
      if (idx_w == IDX_STOP && lvl_i == LV_ZERO) begin
        emit  = 1'b1;
        idx_w = IDX_DONE;
      end
      // Data phase
      if (idx_w < IDX_STOP) begin
        if (lvl_i == LV_ONE && !idx_w[IDX_W-1]) set_o = 1'b1;
        if (lvl_i == LV_IDLE) idx_w = idx_w + IDX_W'(1);
      end
    end
    pos_o = idx_w[POS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= IDX_NONE;
      ctrl_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (evt_i) begin
        idx_q  <= idx_w;
        ctrl_q <= ctrl_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/cpr_pkt_buf.sv
module cpr_pkt_buf #(
  parameter int PKT_BITS = 128,
  localparam int POS_W   = $clog2(PKT_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                set_i,
  input  logic [POS_W-1:0]    pos_i,
  output logic [PKT_BITS-1:0] data_o
);
  for (genvar g = 0; g < PKT_BITS; g++) begin : g_bit
    logic hit, en, d, q;
    always_comb begin
      hit = set_i && (pos_i == POS_W'(g));
      en  = clr_i || hit;
      d   = !clr_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign data_o[g] = q;
  end
endmodule

// File: rtl/cmd_pulse_rx.sv
module cmd_pulse_rx #(
  parameter int PKT_BITS = 128,
  parameter int CTRL_W   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          sel_lines,
  input  logic [CTRL_W-1:0]   player_mask,
  output logic [PKT_BITS-1:0] pkt_data,
  output logic                pkt_valid,
  output logic [CTRL_W-1:0]   ctrl_idx
);
  localparam int POS_W = $clog2(PKT_BITS);

  logic             evt;
  logic [1:0]       prev_w;
  logic             clr, set;
  logic [POS_W-1:0] pos;

  cpr_line_track u_track (
    .clk(clk), .rst_n(rst_n), .lines_i(sel_lines), .evt_o(evt), .prev_o(prev_w)
  );

  cpr_seq #(.PKT_BITS(PKT_BITS), .CTRL_W(CTRL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .lvl_i(sel_lines), .mask_i(player_mask),
    .clr_o(clr), .set_o(set), .pos_o(pos), .valid_o(pkt_valid), .ctrl_o(ctrl_idx)
  );

  cpr_pkt_buf #(.PKT_BITS(PKT_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .set_i(set), .pos_i(pos), .data_o(pkt_data)
  );
endmodule

// File: rtl/cpr_checker.sv
module cpr_checker #(
  parameter int PKT_BITS = 128,
  parameter int CTRL_W   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          sel_lines,
  input logic [CTRL_W-1:0]   player_mask,
  input logic [PKT_BITS-1:0] pkt_data,
  input logic                pkt_valid,
  input logic [CTRL_W-1:0]   ctrl_idx,
  input logic [1:0]          prev_lines
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> !pkt_valid); // R5
  AST_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(sel_lines) == 2'b10); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lines == 2'b00) |=> (pkt_data == '0)); // R2
  AST_HELD_LEVEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lines == prev_lines && sel_lines != 2'b00)
      |=> ($stable(pkt_data) && $stable(ctrl_idx) && !pkt_valid)); // R3
  AST_CTRL_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_idx) |-> ((ctrl_idx & ~$past(player_mask)) == '0)); // R8
  AST_CTRL_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_idx) |-> $past(sel_lines) == 2'b11); // R7
endmodule

bind cmd_pulse_rx cpr_checker #(.PKT_BITS(PKT_BITS), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_lines(sel_lines), .player_mask(player_mask),
  .pkt_data(pkt_data), .pkt_valid(pkt_valid), .ctrl_idx(ctrl_idx), .prev_lines(prev_w)
);

// File: tb/sim_cmd_pulse_rx.sv
`timescale 1ns/1ps
module sim_cmd_pulse_rx;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   sel_lines;
  logic [1:0]   player_mask;
  logic [127:0] pkt_data;
  logic         pkt_valid;
  logic [1:0]   ctrl_idx;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic done = 1'b0;
  logic [1:0] exp_ctrl = 2'd0;

  always #4 clk = ~clk;

  cmd_pulse_rx u0 (
    .clk(clk), .rst_n(rst_n), .sel_lines(sel_lines), .player_mask(player_mask),
    .pkt_data(pkt_data), .pkt_valid(pkt_valid), .ctrl_idx(ctrl_idx)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] next_ctrl(input logic [1:0] c, input logic [1:0] m);
    return (c + 2'd1) & m;
  endfunction

  // Apply a level for 1..3 cycles; pkt_valid must be high only on the first
  // sampled cycle, and only when an emission is expected.
  task automatic drive(input logic [1:0] lvl, input logic exp_emit);
    int hold;
    hold = 1 + int'($urandom % 3);
    @(negedge clk);
    sel_lines = lvl;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R5 valid", {127'd0, pkt_valid}, {127'd0, exp_emit && i == 0});
    end
  endtask

  task automatic send_bits(input logic [127:0] d);
    drive(2'b11, 1'b0);
    for (int k = 0; k < 128; k++) begin
      drive(d[k] ? 2'b01 : 2'b10, 1'b0);
      drive(2'b11, 1'b0);
    end
  endtask

  task automatic send_packet(input logic [127:0] d);
    drive(2'b00, 1'b0);
    send_bits(d);
    drive(2'b10, 1'b1);
    check("R4 packet data", pkt_data, d);
  endtask

  task automatic handshake(input logic [1:0] a, input logic [1:0] b);
    drive(a, 1'b0);
    drive(b, 1'b0);
    drive(2'b11, 1'b0);
    exp_ctrl = next_ctrl(exp_ctrl, player_mask);
    check("R7 R8 ctrl advance", {126'd0, ctrl_idx}, {126'd0, exp_ctrl});
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'h5EED));
    rst_n = 1'b0;
    sel_lines = 2'b11;
    player_mask = 2'd3;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", {127'd0, pkt_valid}, 128'd0);
    check("R1 ctrl in reset", {126'd0, ctrl_idx}, 128'd0);
    check("R1 data in reset", pkt_data, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 data after release", pkt_data, 128'd0);

    // R4 R5 directed and random packets
    send_packet(128'd0);
    send_packet({128{1'b1}});
    send_packet({16{8'h55}});
    send_packet(128'h1);
    for (int p = 0; p < 3; p++) send_packet(rnd128());

    // R7 R8 handshakes with mask 3, both orders
    d = pkt_data;
    handshake(2'b01, 2'b10);
    handshake(2'b10, 2'b01);
    // R3 held idle level repeated has no effect
    drive(2'b11, 1'b0);
    check("R3 held level ctrl", {126'd0, ctrl_idx}, {126'd0, exp_ctrl});
    handshake(2'b01, 2'b10);
    handshake(2'b10, 2'b01);
    check("R8 mask3 wrap to 0", {126'd0, ctrl_idx}, 128'd0);
    // R7 partial handshake does not advance
    drive(2'b01, 1'b0);
    drive(2'b11, 1'b0);
    check("R7 partial no advance", {126'd0, ctrl_idx}, {126'd0, exp_ctrl});
    drive(2'b10, 1'b0);
    drive(2'b11, 1'b0);
    exp_ctrl = next_ctrl(exp_ctrl, player_mask);
    check("R7 completed after partial", {126'd0, ctrl_idx}, {126'd0, exp_ctrl});
    // R9 data held through handshakes
    check("R9 data held", pkt_data, d);
    // R2 restart clears
    drive(2'b00, 1'b0);
    check("R2 restart clears", pkt_data, 128'd0);
    check("R2 restart keeps ctrl", {126'd0, ctrl_idx}, {126'd0, exp_ctrl});

    // R6 wrong levels at stop position
    d = rnd128();
    send_bits(d);
    drive(2'b01, 1'b0);
    drive(2'b11, 1'b0);
    check("R6 data unchanged at stop", pkt_data, d);
    drive(2'b10, 1'b1);
    check("R6 late stop emits data", pkt_data, d);

    // R2 restart in the middle of a packet
    drive(2'b00, 1'b0);
    drive(2'b11, 1'b0);
    for (int k = 0; k < 20; k++) begin
      drive(2'b01, 1'b0);
      drive(2'b11, 1'b0);
    end
    d = rnd128();
    send_packet(d);
    check("R2 mid-packet restart", pkt_data, d);

    // R8 mask 1 alternates, mask 0 stays 0
    player_mask = 2'd1;
    exp_ctrl = ctrl_idx;
    for (int h = 0; h < 3; h++) handshake(2'b01, 2'b10);
    player_mask = 2'd0;
    handshake(2'b10, 2'b01);
    handshake(2'b01, 2'b10);
    check("R8 mask0 index zero", {126'd0, ctrl_idx}, 128'd0);
    check("R9 data held after mask change", pkt_data, d);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule